// File: doc/BRIEF.md
# Split-Aware DMA Descriptor Builder

This block converts a single transfer request into one or two fixed-size DMA descriptors and stores them in a descriptor ring in local memory. A request names a 64-bit host address, a 32-bit local address, a byte length and a direction. Each descriptor is four 64-bit words. The block writes one word per cycle to a memory write port and then reports the ring slot that follows the last descriptor it wrote.

A transfer that fits in one line becomes a single descriptor of one line. A longer transfer becomes a pitched descriptor made of several full-size lines. If whole 16-byte units are left over, a second descriptor of one line covers them. The completion interrupt is requested only by the last descriptor of a request. The ring head wraps at the configured depth, so software can keep handing over requests without managing the index itself.

Top module: `xfer_desc_builder`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_we` and `done` are 0, and the ring head is slot 0, so the first descriptor goes to word address 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge through the done cycle. Requests presented while the block is busy have no effect.
- R3: Each descriptor is written one word per cycle, starting the cycle after acceptance, with no gaps. The order is word 0 host address, word 1 pitch word, word 2 command word, word 3 zero. A word's address is slot*4 + word.
- R4: Command word layout:
  - bit 31: interrupt enable
  - bits 27:16: line count
  - bit 15: local interrupt request
  - bits 14:4: line size in 16-byte units
  - bit 1: always 1
  - all other bits: 0
- R5: Pitch word layout:
  - bits 62:51: local pitch
  - bits 46:35: host pitch (same value as the local pitch)
  - bit 31: 1 for upstream
  - bits 29:4: local address bits 29:4
  - bit 0: always 1
  - all other bits: 0
- R6: A length of at most 32752 bytes yields one descriptor with line count 1, pitch 1 and line size equal to length/16.
- R7: A longer length yields a first descriptor with:
  - line count: the low 12 bits of length/32752
  - line size: 0x7FF
  - pitch: 4094
- R8: For a long transfer, let the remainder be (length − count×32752)/16, with count the full quotient. If the remainder is nonzero, a second descriptor follows in the next slot. Its host and local addresses are advanced by count×32752 bytes. It has line count 1, pitch 1 and line size equal to the remainder.
- R9: The interrupt-enable and request bits are 1 only in the last descriptor of a request. They are 0 in a first descriptor that is followed by a remainder descriptor.
- R10: `done` is high for exactly one cycle, the cycle after the last word written. `done_index` then equals the slot after the last descriptor, modulo the ring depth.
- R11: At the boundaries:
  - 32752 bytes is a single descriptor.
  - 32760 bytes is a multi-line descriptor with no remainder descriptor, because its leftover is under 16 bytes.
  - 32768 bytes gives two descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_host_addr | input | 64 | Host-side start address |
| req_local_addr | input | 32 | Local-side start address |
| req_len | input | 32 | Transfer length in bytes |
| req_upstream | input | 1 | 1 = local-to-host direction |
| mem_we | output | 1 | Ring memory write strobe |
| mem_addr | output | log2(RING_DEPTH)+2 | Ring word address (slot*4 + word) |
| mem_wdata | output | 64 | Descriptor word being written |
| done | output | 1 | One-cycle completion pulse |
| done_index | output | log2(RING_DEPTH) | Next free ring slot, valid with done |

## Verification
Take the edge that accepts a request as edge 0. The host word of the first descriptor is on the write port in the cycle after edge 0. The remaining words follow one per cycle: 4 cycles for one descriptor, 8 for two. `done` comes in the next cycle, and `req_ready` returns one cycle after that. The bench uses a behavioural model that turns each accepted request into a queue of expected per-cycle events. At every falling edge it pops one event and compares the outputs against it: address, data, strobe, done, index and ready. An idle cycle is checked for no writes and for ready high. Any shift of a single cycle is therefore reported as a mismatch.

// File: rtl/xdb_pkg.sv
package xdb_pkg;
    localparam int HOST_W      = 64;
    localparam int LOC_W       = 32;
    localparam int LEN_W       = 32;
    localparam int WORD_W      = 64;
    localparam int DESC_WORDS  = 4;
    localparam int SIZE_W      = 11;
    localparam int CNT_W       = 12;
    localparam int PITCH_W     = 12;
    localparam int UNIT_SHIFT  = 4;
    localparam int PITCH_SHIFT = 3;

    // largest line in bytes and the pitch used for multi-line descriptors
    localparam int MAX_LINE_BYTES = ((1 << SIZE_W) - 1) << UNIT_SHIFT;
    localparam int MULTI_PITCH    = MAX_LINE_BYTES >> PITCH_SHIFT;

    // command word fields
    localparam int CW_IRQ_EN   = 31;
    localparam int CW_CNT_LSB  = 16;
    localparam int CW_IRQ_REQ  = 15;
    localparam int CW_SIZE_LSB = 4;
    localparam int CW_ID       = 1;

    // pitch word fields
    localparam int PW_LPITCH_LSB = 51;
    localparam int PW_HPITCH_LSB = 35;
    localparam int PW_UPSTREAM   = 31;
    localparam int PW_ADDR_MSB   = 29;
    localparam int PW_ADDR_LSB   = 4;
    localparam int PW_ID         = 0;
    localparam logic [WORD_W-1:0] PW_ADDR_MASK =
        ((64'd1 << (PW_ADDR_MSB - PW_ADDR_LSB + 1)) - 64'd1) << PW_ADDR_LSB;

    typedef logic [DESC_WORDS-1:0][WORD_W-1:0] desc_t;

    typedef struct packed {
        logic [CNT_W-1:0]   count;
        logic [SIZE_W-1:0]  size;
        logic [PITCH_W-1:0] pitch;
    } shape_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } st_e;
endpackage

// File: rtl/xdb_split.sv
module xdb_split
    import xdb_pkg::*;
(
    input  logic [LEN_W-1:0] len_i,
    output shape_t           head_o,
    output shape_t           tail_o,
    output logic             tail_en_o,
    output logic [LEN_W-1:0] covered_o
);
    localparam logic [LEN_W-1:0] MAXB = LEN_W'(MAX_LINE_BYTES);

    logic             multi;
    logic [LEN_W-1:0] quot;
    logic [LEN_W-1:0] covered;

    always_comb begin
        multi   = len_i > MAXB;
        quot    = len_i / MAXB;
        covered = quot * MAXB;

        tail_o.count = CNT_W'(1);
        tail_o.pitch = PITCH_W'(1);
        tail_o.size  = SIZE_W'((len_i - covered) >> UNIT_SHIFT);

        if (multi) begin
            head_o.count = quot[CNT_W-1:0];
            head_o.size  = SIZE_W'(MAX_LINE_BYTES >> UNIT_SHIFT);
            head_o.pitch = PITCH_W'(MULTI_PITCH);
            tail_en_o    = |tail_o.size;
            covered_o    = covered;
        end else begin
            head_o.count = CNT_W'(1);
            head_o.size  = SIZE_W'(len_i >> UNIT_SHIFT);
            head_o.pitch = PITCH_W'(1);
            tail_en_o    = 1'b0;
            covered_o    = '0;
        end
    end

    // R7: full lines never cover more than the length, and leave less than one line
    always_comb begin
        if (multi) begin
            a_r7_cover: assert (covered <= len_i && (len_i - covered) < MAXB)
                else $error("line split exceeds length");
        end
    end
endmodule

// File: rtl/xdb_pack.sv
module xdb_pack
    import xdb_pkg::*;
(
    input  logic [HOST_W-1:0] host_i,
    input  logic [LOC_W-1:0]  loc_i,
    input  logic              up_i,
    input  shape_t            shape_i,
    input  logic              irq_i,
    output desc_t             desc_o
);
    logic [WORD_W-1:0] pw;
    logic [WORD_W-1:0] cw;

    always_comb begin
        pw = '0;
        pw[PW_LPITCH_LSB +: PITCH_W] = shape_i.pitch;
        pw[PW_HPITCH_LSB +: PITCH_W] = shape_i.pitch;
        pw[PW_UPSTREAM]              = up_i;
        pw = pw | ({{(WORD_W-LOC_W){1'b0}}, loc_i} & PW_ADDR_MASK);
        pw[PW_ID]                    = 1'b1;

        cw = '0;
        cw[CW_IRQ_EN]                = irq_i;
        cw[CW_CNT_LSB +: CNT_W]      = shape_i.count;
        cw[CW_IRQ_REQ]               = irq_i;
        cw[CW_SIZE_LSB +: SIZE_W]    = shape_i.size;
        cw[CW_ID]                    = 1'b1;

        desc_o    = '0;
        desc_o[0] = host_i;
        desc_o[1] = pw;
        desc_o[2] = cw;
    end

    // R4 / R5: the constant-one flags are always present in their words
    always_comb begin
        a_r4_id_flags: assert (desc_o[2][CW_ID] && desc_o[1][PW_ID] && desc_o[3] == '0)
            else $error("descriptor id flags missing");
    end
endmodule

// File: rtl/xfer_desc_builder.sv
module xfer_desc_builder
    import xdb_pkg::*;
#(
    parameter int RING_DEPTH = 128,
    localparam int IW = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1,
    localparam int AW = IW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [HOST_W-1:0] req_host_addr,
    input  logic [LOC_W-1:0]  req_local_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_upstream,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              done,
    output logic [IW-1:0]     done_index
);
    typedef struct packed {
        st_e               st;
        logic [IW-1:0]     head;
        logic [IW-1:0]     cur;
        logic [1:0]        word;
        logic              second;
        logic [HOST_W-1:0] host;
        logic [LOC_W-1:0]  loc;
        logic              up;
        shape_t            s0;
        shape_t            s1;
        logic              tail_en;
        logic [LEN_W-1:0]  covered;
    } state_t;

    state_t q, d;

    function automatic logic [IW-1:0] ring_next(input logic [IW-1:0] i);
        return (i == IW'(RING_DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    // length arithmetic on the incoming request
    shape_t           sp_head, sp_tail;
    logic             sp_tail_en;
    logic [LEN_W-1:0] sp_covered;

    xdb_split u_split (
        .len_i     (req_len),
        .head_o    (sp_head),
        .tail_o    (sp_tail),
        .tail_en_o (sp_tail_en),
        .covered_o (sp_covered)
    );

    // one packer for the leading descriptor and one for the remainder descriptor
    logic [HOST_W-1:0] host_v  [2];
    logic [LOC_W-1:0]  loc_v   [2];
    shape_t            shape_v [2];
    logic              irq_v   [2];
    desc_t             desc_v  [2];

    always_comb begin
        host_v[0]  = q.host;
        host_v[1]  = q.host + HOST_W'(q.covered);
        loc_v[0]   = q.loc;
        loc_v[1]   = q.loc + q.covered;
        shape_v[0] = q.s0;
        shape_v[1] = q.s1;
        irq_v[0]   = !q.tail_en;
        irq_v[1]   = 1'b1;
    end

    for (genvar g = 0; g < 2; g++) begin : g_pack
        xdb_pack u_pack (
            .host_i  (host_v[g]),
            .loc_i   (loc_v[g]),
            .up_i    (q.up),
            .shape_i (shape_v[g]),
            .irq_i   (irq_v[g]),
            .desc_o  (desc_v[g])
        );
    end

    always_comb begin
        d          = q;
        req_ready  = (q.st == ST_IDLE);
        mem_we     = 1'b0;
        mem_addr   = {q.cur, q.word};
        mem_wdata  = desc_v[q.second][q.word];
        done       = 1'b0;
        done_index = q.head;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st      = ST_WRITE;
                    d.cur     = q.head;
                    d.word    = 2'd0;
                    d.second  = 1'b0;
                    d.host    = req_host_addr;
                    d.loc     = req_local_addr;
                    d.up      = req_upstream;
                    d.s0      = sp_head;
                    d.s1      = sp_tail;
                    d.tail_en = sp_tail_en;
                    d.covered = sp_covered;
                end
            end
            ST_WRITE: begin
                mem_we = 1'b1;
                d.word = q.word + 2'd1;
                if (q.word == 2'd3) begin
                    if (!q.second && q.tail_en) begin
                        d.second = 1'b1;
                        d.cur    = ring_next(q.cur);
                    end else begin
                        d.st   = ST_DONE;
                        d.head = ring_next(q.cur);
                    end
                end
            end
            ST_DONE: begin
                done = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: no acceptance while descriptor words are being written
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !req_ready);

    // R3: words inside a descriptor come on consecutive cycles and addresses
    a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr[1:0] != 2'd0) |-> ($past(mem_we) && mem_addr == $past(mem_addr) + AW'(1)));

    // R9: a command word asking for an interrupt belongs to the last descriptor
    a_r9_irq_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr[1:0] == 2'd2 && mem_wdata[CW_IRQ_EN]) |=> ##1 done);

    // R10: done follows the final word and lasts one cycle
    a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_we) && $past(mem_addr[1:0]) == 2'd3));

    a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_xfer_desc_builder.sv
module sim_xfer_desc_builder;
    localparam int TCLK  = 10;
    localparam int DEPTH = 128;
    localparam int IW    = $clog2(DEPTH);
    localparam int AW    = IW + 2;
    localparam int MAXB  = 32752;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [63:0]       req_host_addr = '0;
    logic [31:0]       req_local_addr = '0;
    logic [31:0]       req_len = '0;
    logic              req_upstream = 1'b0;
    logic              mem_we;
    logic [AW-1:0]     mem_addr;
    logic [63:0]       mem_wdata;
    logic              done;
    logic [IW-1:0]     done_index;

    always #(TCLK/2) clk = ~clk;

    xfer_desc_builder #(.RING_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_host_addr(req_host_addr), .req_local_addr(req_local_addr),
        .req_len(req_len), .req_upstream(req_upstream),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .done_index(done_index)
    );

    typedef struct {
        bit              is_done;
        int unsigned     addr;
        longint unsigned data;
        int unsigned     idx;
        string           req;
    } exp_t;

    exp_t expq[$];
    int   model_idx = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   active = 1'b0;

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void push_desc(input longint unsigned host, input int unsigned loc,
                                      input bit up, input int unsigned cnt,
                                      input int unsigned size, input int unsigned pitch,
                                      input bit irq, input string tag);
        exp_t e;
        longint unsigned pw, cw;
        pw = (longint'(pitch) << 51) | (longint'(pitch) << 35) | (longint'(up) << 31)
           | (longint'(loc) & 64'h3FFF_FFF0) | 64'd1;
        cw = (longint'(irq) << 31) | (longint'(cnt & 32'hFFF) << 16) | (longint'(irq) << 15)
           | (longint'(size & 32'h7FF) << 4) | 64'd2;
        e.is_done = 1'b0;
        e.idx = 0;
        e.addr = model_idx * 4;     e.data = host; e.req = {tag, " R3 host word"};   expq.push_back(e);
        e.addr = model_idx * 4 + 1; e.data = pw;   e.req = {tag, " R5 pitch word"};  expq.push_back(e);
        e.addr = model_idx * 4 + 2; e.data = cw;   e.req = {tag, " R4 R9 cmd word"}; expq.push_back(e);
        e.addr = model_idx * 4 + 3; e.data = 0;    e.req = {tag, " R3 zero word"};   expq.push_back(e);
        model_idx = (model_idx + 1) % DEPTH;
    endfunction

    // behavioural model of one accepted request (R6, R7, R8, R9, R10)
    function automatic void model_req(input longint unsigned host, input int unsigned loc,
                                      input int unsigned len, input bit up);
        exp_t e;
        if (len <= MAXB) begin
            push_desc(host, loc, up, 1, len >> 4, 1, 1'b1, "R6");
        end else begin
            int unsigned q   = len / MAXB;
            int unsigned tot = q * MAXB;
            int unsigned r   = (len - tot) >> 4;
            push_desc(host, loc, up, q, 12'h7FF, 4094, (r == 0), "R7");
            if (r != 0)
                push_desc(host + longint'(tot), loc + tot, up, 1, r, 1, 1'b1, "R8");
        end
        e.is_done = 1'b1; e.addr = 0; e.data = 0; e.idx = model_idx; e.req = "R10 done";
        expq.push_back(e);
    endfunction

    // cycle-by-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (active) begin
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
                if (e.is_done) begin
                    chk(done == 1'b1, "R10 done pulse", done, 1);
                    chk(done_index == IW'(e.idx), "R10 done index", done_index, e.idx);
                    chk(mem_we == 1'b0, "R10 no write in done cycle", mem_we, 0);
                end else begin
                    chk(mem_we == 1'b1, {e.req, " strobe"}, mem_we, 1);
                    chk(mem_addr == AW'(e.addr), {e.req, " address"}, mem_addr, e.addr);
                    chk(mem_wdata == e.data, e.req, mem_wdata, e.data);
                    chk(done == 1'b0, {e.req, " done low"}, done, 0);
                end
            end else begin
                chk(mem_we == 1'b0 && done == 1'b0, "R2 idle outputs quiet",
                    {mem_we, done}, 0);
                chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
            end
            if (req_valid && req_ready)
                model_req(req_host_addr, req_local_addr, req_len, req_upstream);
        end
    end

    task automatic send(input longint unsigned host, input int unsigned loc,
                        input int unsigned len, input bit up);
        req_host_addr  = host;
        req_local_addr = loc;
        req_len        = len;
        req_upstream   = up;
        req_valid      = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(TCLK * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: idle outputs after reset; ring head 0 is implied by model_idx starting at 0
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(mem_we == 1'b0, "R1 no write after reset", mem_we, 0);
        chk(done == 1'b0, "R1 no done after reset", done, 0);
        active = 1'b1;
        @(posedge clk);
        #1;
        // R6 short downstream transfer, first slot 0 (R1)
        send(64'h0000_0012_3456_7000, 32'h8123_4560, 64, 1'b0);
        // R11 exact single-line limit, upstream
        send(64'h0000_0000_0010_0000, 32'hC000_0010, 32752, 1'b1);
        // R11 / R8 just past the limit: one line plus a 16-byte remainder, R9 moves irq
        send(64'h0000_0001_0000_0000, 32'h4000_0000, 32768, 1'b0);
        // R7 exact two lines, no remainder
        send(64'h0000_0000_2000_0000, 32'h0000_1000, 65504, 1'b1);
        // R11 leftover below 16 bytes gives no remainder descriptor
        send(64'h0000_0000_0000_8000, 32'h0001_0000, 32760, 1'b0);
        // R8 remainder address carry into upper host bits
        send(64'h0000_0000_FFFF_F000, 32'h3FFF_0000, 100000, 1'b1);
        // R6 zero length
        send(64'h0, 32'h0, 0, 1'b0);
        // R7 large count truncated to 12 bits
        send(64'h0000_0000_4000_0000, 32'h0, 32'h0800_0000, 1'b0);
        // R10 ring wrap over several passes, back-to-back with valid held (R2)
        for (int i = 0; i < 130; i++)
            send(64'h0000_0000_0100_0000 + longint'(i) * 64'h1_0000,
                 32'h0020_0000 + i * 32'h100, 40000 + i * 16, i[0]);
        while (expq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule